// File: doc/BRIEF.md
# Exception Entry and Mode Banking Controller

This block tracks the processor's current status word and changes processor mode when an exception or interrupt is taken. Seven event request lines go through a fixed priority arbiter. Normal and fast interrupts can be masked by their disable bits in the status word. When an event is accepted, the block does the following in one clock edge:

- copies the status word into the saved status register of the target mode;
- switches mode, disables interrupts and forces the 32-bit instruction state;
- issues a write of the return address into the target mode's link register;
- loads the program counter with the event's vector.

A return request reverses this. The status word is restored from the active mode's saved copy, and the program counter is reloaded from the active mode's link register.

The block also maps a logical register number (r0 to r15) under the current mode onto a physical index of a 37-entry register file. Indices 0 to 30 hold general registers, including the banked copies. The remaining six entries are the current and five saved status words, and this block keeps those itself. System mode shares every physical register with user mode.

Top module: `exc_mode_ctrl`

## Requirements
- R1: After rst_ni is released, sr_o is 0x000000D3: supervisor mode 0x13 in bits [4:0], instruction-state bit 5 clear, fast-interrupt disable bit 6 set and interrupt disable bit 7 set. spsr_o reads 0x00000010, and pc_load_o and lr_we_o are low.
- R2: Mode codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. preg_o maps logical register n as follows:
  - r0 to r7 and r15 map to n in every mode, and user and system modes map every register to n.
  - Fast-interrupt mode maps r8 to r14 to n+8.
  - For r13 and r14, interrupt mode maps to 23 and 24, supervisor to 25 and 26, abort to 27 and 28, and undefined to 29 and 30.
  - All other cases map to n.
- R3: evt_i bits are [0] reset, [1] undefined, [2] software interrupt, [3] prefetch abort, [4] data abort, [5] interrupt and [6] fast interrupt. When several are pending, the winner in falling priority is reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, then software interrupt.
- R4: On the edge that accepts an event, the status word of that edge is stored as the target mode's saved status. sr_o then takes the target mode, with bit 5 cleared, bit 7 set and bits [31:8] kept. Reset and software interrupt target supervisor mode, both aborts target abort mode, and undefined targets undefined mode. spsr_o shows the saved status of the current mode.
- R5: Fast-interrupt and reset entries set bit 6. All other entries leave bit 6 unchanged.
- R6: In the cycle after acceptance, pc_load_o pulses for one cycle. pc_val_o is the base plus the event's evt_i bit number times 16. The base is 0xFFFF0000 when hivec_i is high and 0 otherwise.
- R7: In the same cycle, lr_we_o pulses with lr_widx_o set to the target mode's r14 index and lr_wdata_o set to the pc_i value sampled at acceptance.
- R8: An interrupt request is ignored while bit 7 is set. A fast-interrupt request is ignored while bit 6 is set.
- R9: lr_ridx_o is the physical index of r14 in the current mode. In a mode with a saved status, ret_i restores sr_o from that saved status and pulses pc_load_o with pc_val_o set to the link_rdata_i value sampled with ret_i, without a link write. In user or system mode, ret_i has no effect.
- R10: A status write through sr_we_i updates every bit except bit 5, which keeps its value. A write whose bits [4:0] are not one of the seven mode codes is ignored entirely.
- R11: An accepted event takes precedence over ret_i, and ret_i takes precedence over a status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event request lines |
| ret_i | input | 1 | Exception return request |
| pc_i | input | DW | Return address captured on entry |
| hivec_i | input | 1 | Selects the high vector base |
| sr_we_i | input | 1 | Status word write enable |
| sr_wdata_i | input | DW | Status word write data |
| sr_o | output | DW | Current status word |
| spsr_o | output | DW | Saved status of the current mode |
| lreg_i | input | 4 | Logical register number to map |
| preg_o | output | PIDX_W | Physical index of lreg_i in the current mode |
| lr_ridx_o | output | PIDX_W | Physical index of the current mode's r14 |
| link_rdata_i | input | DW | Link register contents read at lr_ridx_o |
| lr_we_o | output | 1 | Link register write strobe |
| lr_widx_o | output | PIDX_W | Link register write index |
| lr_wdata_o | output | DW | Link register write data |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_val_o | output | DW | Program counter load value |

## Verification
The register map is swept over all seven modes and all sixteen logical registers, so an error in any single bank boundary shows up. All 127 non-empty combinations of event requests are applied from an unmasked system-mode state with both vector bases. This separates priority mistakes, wrong target modes, wrong vector slots and wrong disable-bit handling from one another. Directed sequences then cover the remaining behaviour:
- masked and unmasked interrupts;
- a return from a banked mode and a return attempted in system mode;
- an event colliding with a return;
- status writes with an unassigned mode code and with the instruction-state bit set.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  typedef enum logic [4:0] {
    M_USR = 5'h10,
    M_FIQ = 5'h11,
    M_IRQ = 5'h12,
    M_SVC = 5'h13,
    M_ABT = 5'h17,
    M_UND = 5'h1B,
    M_SYS = 5'h1F
  } mode_e;

  localparam int NUM_EVT  = 7;
  localparam int EV_RST   = 0;
  localparam int EV_UND   = 1;
  localparam int EV_SWI   = 2;
  localparam int EV_PABT  = 3;
  localparam int EV_DABT  = 4;
  localparam int EV_IRQ   = 5;
  localparam int EV_FIQ   = 6;

  localparam int T_BIT    = 5;
  localparam int F_BIT    = 6;
  localparam int I_BIT    = 7;
  localparam int NUM_SPSR = 5;

  function automatic logic mode_ok(logic [4:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // saved-status bank of a mode, -1 when the mode has none
  function automatic int spsr_bank(logic [4:0] m);
    case (m)
      M_FIQ:   return 0;
      M_IRQ:   return 1;
      M_SVC:   return 2;
      M_ABT:   return 3;
      M_UND:   return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [4:0] evt_mode(logic [2:0] idx);
    case (int'(idx))
      EV_UND:           return M_UND;
      EV_PABT, EV_DABT: return M_ABT;
      EV_IRQ:           return M_IRQ;
      EV_FIQ:           return M_FIQ;
      default:          return M_SVC;
    endcase
  endfunction
endpackage

// File: rtl/exc_bank_map.sv
module exc_bank_map
  import exc_ctrl_pkg::*;
#(
  parameter int PIDX_W = 6
) (
  input  logic [4:0]        mode_i,
  input  logic [3:0]        lreg_i,
  output logic [PIDX_W-1:0] pidx_o
);
  localparam int FIQ_OFS   = 8;   // r8 of fast-interrupt bank sits at 16
  localparam int PAIR_BASE = 23;  // first banked r13/r14 pair

  int bank;

  always_comb begin
    bank   = spsr_bank(mode_i);
    pidx_o = PIDX_W'(lreg_i);
    if (lreg_i != 4'd15) begin
      if (mode_i == M_FIQ && lreg_i >= 4'd8)
        pidx_o = PIDX_W'(int'(lreg_i) + FIQ_OFS);
      else if (lreg_i >= 4'd13 && bank >= 1)
        pidx_o = PIDX_W'(PAIR_BASE + 2 * (bank - 1) + int'(lreg_i) - 13);
    end
  end
endmodule

// File: rtl/exc_evt_arb.sv
module exc_evt_arb
  import exc_ctrl_pkg::*;
(
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               irq_mask_i,
  input  logic               fiq_mask_i,
  output logic               take_o,
  output logic [2:0]         idx_o
);
  localparam int PRIO [NUM_EVT] = '{EV_RST, EV_DABT, EV_FIQ, EV_IRQ,
                                    EV_PABT, EV_UND, EV_SWI};

  logic [NUM_EVT-1:0] live;

  always_comb begin
    live          = evt_i;
    live[EV_IRQ]  = evt_i[EV_IRQ] & ~irq_mask_i;
    live[EV_FIQ]  = evt_i[EV_FIQ] & ~fiq_mask_i;
    take_o        = 1'b0;
    idx_o         = '0;
    // walk lowest priority first so the highest one wins
    for (int k = NUM_EVT - 1; k >= 0; k--) begin
      if (live[PRIO[k]]) begin
        take_o = 1'b1;
        idx_o  = 3'(PRIO[k]);
      end
    end
  end
endmodule

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          NUM_PHYS   = 37,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000,
  parameter int          SLOT_BYTES = 16,
  localparam int         PIDX_W     = $clog2(NUM_PHYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ret_i,
  input  logic [DW-1:0]      pc_i,
  input  logic               hivec_i,
  input  logic               sr_we_i,
  input  logic [DW-1:0]      sr_wdata_i,
  output logic [DW-1:0]      sr_o,
  output logic [DW-1:0]      spsr_o,
  input  logic [3:0]         lreg_i,
  output logic [PIDX_W-1:0]  preg_o,
  output logic [PIDX_W-1:0]  lr_ridx_o,
  input  logic [DW-1:0]      link_rdata_i,
  output logic               lr_we_o,
  output logic [PIDX_W-1:0]  lr_widx_o,
  output logic [DW-1:0]      lr_wdata_o,
  output logic               pc_load_o,
  output logic [DW-1:0]      pc_val_o
);
  localparam logic [DW-1:0] SR_RST   = DW'(32'h0000_00D3);
  localparam logic [DW-1:0] SPSR_RST = DW'(32'h0000_0010);

  logic [DW-1:0]     cpsr_q;
  logic [DW-1:0]     spsr_q [NUM_SPSR];
  logic [4:0]        cur_mode, tgt_mode;
  logic              take;
  logic [2:0]        evt_idx;
  int                cur_bank, tgt_bank;
  logic [DW-1:0]     entry_sr, vec_addr, cur_spsr;
  logic [PIDX_W-1:0] tgt_lr_idx;
  logic              do_ret, do_wr;

  assign cur_mode = cpsr_q[4:0];
  assign cur_bank = spsr_bank(cur_mode);
  assign tgt_mode = evt_mode(evt_idx);
  assign tgt_bank = spsr_bank(tgt_mode);

  exc_evt_arb i_arb (
    .evt_i      (evt_i),
    .irq_mask_i (cpsr_q[I_BIT]),
    .fiq_mask_i (cpsr_q[F_BIT]),
    .take_o     (take),
    .idx_o      (evt_idx)
  );

  exc_bank_map #(.PIDX_W(PIDX_W)) i_map_port (
    .mode_i (cur_mode), .lreg_i (lreg_i), .pidx_o (preg_o)
  );

  exc_bank_map #(.PIDX_W(PIDX_W)) i_map_rlr (
    .mode_i (cur_mode), .lreg_i (4'd14), .pidx_o (lr_ridx_o)
  );

  exc_bank_map #(.PIDX_W(PIDX_W)) i_map_wlr (
    .mode_i (tgt_mode), .lreg_i (4'd14), .pidx_o (tgt_lr_idx)
  );

  always_comb begin
    entry_sr        = cpsr_q;
    entry_sr[4:0]   = tgt_mode;
    entry_sr[T_BIT] = 1'b0;
    entry_sr[I_BIT] = 1'b1;
    if (int'(evt_idx) == EV_FIQ || int'(evt_idx) == EV_RST)
      entry_sr[F_BIT] = 1'b1;
  end

  assign vec_addr = (hivec_i ? DW'(HIVEC_BASE) : '0) + DW'(evt_idx) * DW'(SLOT_BYTES);

  always_comb begin
    cur_spsr = '0;
    for (int b = 0; b < NUM_SPSR; b++)
      if (cur_bank == b) cur_spsr = spsr_q[b];
  end

  assign spsr_o = cur_spsr;
  assign do_ret = !take && ret_i && (cur_bank >= 0);
  assign do_wr  = !take && !do_ret && sr_we_i && mode_ok(sr_wdata_i[4:0]);

  for (genvar b = 0; b < NUM_SPSR; b++) begin : g_spsr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    spsr_q[b] <= SPSR_RST;
      else if (take && tgt_bank == b) spsr_q[b] <= cpsr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q     <= SR_RST;
      pc_load_o  <= 1'b0;
      pc_val_o   <= '0;
      lr_we_o    <= 1'b0;
      lr_widx_o  <= '0;
      lr_wdata_o <= '0;
    end else begin
      pc_load_o <= 1'b0;
      lr_we_o   <= 1'b0;
      if (take) begin
        cpsr_q     <= entry_sr;
        pc_load_o  <= 1'b1;
        pc_val_o   <= vec_addr;
        lr_we_o    <= 1'b1;
        lr_widx_o  <= tgt_lr_idx;
        lr_wdata_o <= pc_i;
      end else if (do_ret) begin
        cpsr_q    <= cur_spsr;
        pc_load_o <= 1'b1;
        pc_val_o  <= link_rdata_i;
      end else if (do_wr) begin
        cpsr_q        <= sr_wdata_i;
        cpsr_q[T_BIT] <= cpsr_q[T_BIT];
      end
    end
  end

  assign sr_o = cpsr_q;
endmodule

// File: rtl/exc_mode_ctrl_chk.sv
module exc_mode_ctrl_chk
  import exc_ctrl_pkg::*;
#(
  parameter int DW         = 32,
  parameter int SLOT_BYTES = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               ret_i,
  input logic [DW-1:0]      sr_o,
  input logic [DW-1:0]      spsr_o,
  input logic [DW-1:0]      link_rdata_i,
  input logic               lr_we_o,
  input logic               pc_load_o,
  input logic [DW-1:0]      pc_val_o
);
  logic ret_mode;
  assign ret_mode = spsr_bank(sr_o[4:0]) >= 0;

  a_r10_mode_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ok(sr_o[4:0]));

  a_r4_entry_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> (pc_load_o && sr_o[I_BIT] && !sr_o[T_BIT]));

  a_r5_fiq_masks_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_we_o && sr_o[4:0] == M_FIQ) |-> sr_o[F_BIT]);

  a_r6_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> ((pc_val_o & DW'(SLOT_BYTES - 1)) == '0));

  a_r8_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == 7'b010_0000 && sr_o[I_BIT] && !ret_i) |=> !pc_load_o);

  a_r9_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && evt_i == '0 && ret_mode) |=>
      (pc_load_o && !lr_we_o && pc_val_o == $past(link_rdata_i) && sr_o == $past(spsr_o)));

  a_r11_event_beats_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[EV_RST] && ret_i) |=> lr_we_o);
endmodule

bind exc_mode_ctrl exc_mode_ctrl_chk #(.DW(DW), .SLOT_BYTES(SLOT_BYTES)) i_chk (.*);

// File: tb/test_exc_mode_ctrl.sv
`timescale 1ns/1ps
module test_exc_mode_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  evt_i = '0;
  logic        ret_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        hivec_i = 1'b0;
  logic        sr_we_i = 1'b0;
  logic [31:0] sr_wdata_i = '0;
  logic [31:0] sr_o, spsr_o, link_rdata_i, lr_wdata_o, pc_val_o;
  logic [3:0]  lreg_i = '0;
  logic [5:0]  preg_o, lr_ridx_o, lr_widx_o;
  logic        lr_we_o, pc_load_o;
  int          checks = 0;
  int          fails = 0;

  always #2 clk_i = ~clk_i;

  exc_mode_ctrl i_exc_mode_ctrl (
    .clk_i, .rst_ni, .evt_i, .ret_i, .pc_i, .hivec_i, .sr_we_i, .sr_wdata_i,
    .sr_o, .spsr_o, .lreg_i, .preg_o, .lr_ridx_o, .link_rdata_i, .lr_we_o,
    .lr_widx_o, .lr_wdata_o, .pc_load_o, .pc_val_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; evt_i = '0; ret_i = 1'b0; sr_we_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr_sr(logic [31:0] v);
    sr_we_i = 1'b1; sr_wdata_i = v;
    @(negedge clk_i);
    sr_we_i = 1'b0;
  endtask

  function automatic int exp_pidx(logic [4:0] m, int l);
    if (l < 8 || l == 15) return l;
    if (m == 5'h11) return l + 8;
    if (l < 13) return l;
    case (m)
      5'h12:   return 23 + l - 13;
      5'h13:   return 25 + l - 13;
      5'h17:   return 27 + l - 13;
      5'h1B:   return 29 + l - 13;
      default: return l;
    endcase
  endfunction

  function automatic int winner(logic [6:0] e);
    int ord [7] = '{0, 4, 6, 5, 3, 1, 2};
    for (int k = 0; k < 7; k++) if (e[ord[k]]) return ord[k];
    return -1;
  endfunction

  function automatic logic [4:0] tmode(int w);
    case (w)
      1:       return 5'h1B;
      3, 4:    return 5'h17;
      5:       return 5'h12;
      6:       return 5'h11;
      default: return 5'h13;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    do_reset();
    // R1 reset state
    chk("R1 sr", sr_o, 32'h0000_00D3);
    chk("R1 spsr", spsr_o, 32'h0000_0010);
    chk("R1 pc_load", {31'b0, pc_load_o}, 0);
    chk("R1 lr_we", {31'b0, lr_we_o}, 0);

    // R2 full map sweep, R9 read-link index
    for (int mi = 0; mi < 7; mi++) begin
      wr_sr(32'hC0 | {27'b0, modes[mi]});
      chk("R2 mode set", sr_o, 32'hC0 | {27'b0, modes[mi]});
      chk("R9 lr_ridx", {26'b0, lr_ridx_o}, 32'(exp_pidx(modes[mi], 14)));
      for (int l = 0; l < 16; l++) begin
        lreg_i = 4'(l);
        #1;
        chk("R2 preg", {26'b0, preg_o}, 32'(exp_pidx(modes[mi], l)));
      end
    end

    // R3..R7 event sweep over all request combinations and both bases
    for (int hv = 0; hv < 2; hv++) begin
      for (int c = 1; c < 128; c++) begin
        int w;
        logic [31:0] esr;
        do_reset();
        wr_sr(32'hA000_001F);
        w = winner(7'(c));
        esr = 32'hA000_0080 | {27'b0, tmode(w)} | ((w == 0 || w == 6) ? 32'h40 : 32'h0);
        evt_i = 7'(c); pc_i = 32'h1000 + 32'(c) * 4; hivec_i = hv[0];
        @(negedge clk_i);
        evt_i = '0;
        chk("R3 R4 R5 sr", sr_o, esr);
        chk("R4 spsr", spsr_o, 32'hA000_001F);
        chk("R6 pc", pc_val_o, (hv != 0 ? 32'hFFFF_0000 : 32'h0) + 32'(w) * 16);
        chk("R6 pc_load", {31'b0, pc_load_o}, 1);
        chk("R7 lr idx", {26'b0, lr_widx_o}, 32'(exp_pidx(tmode(w), 14)));
        chk("R7 lr data", lr_wdata_o, 32'h1000 + 32'(c) * 4);
        chk("R7 lr_we", {31'b0, lr_we_o}, 1);
        @(negedge clk_i);
        chk("R6 pulse", {31'b0, pc_load_o}, 0);
      end
    end
    hivec_i = 1'b0;

    // R8 masking
    do_reset();
    wr_sr(32'h0000_00DF);
    evt_i = 7'h20; @(negedge clk_i); evt_i = '0;
    chk("R8 irq masked", {31'b0, pc_load_o}, 0);
    chk("R8 irq masked sr", sr_o, 32'h0000_00DF);
    evt_i = 7'h40; @(negedge clk_i); evt_i = '0;
    chk("R8 fiq masked", {31'b0, pc_load_o}, 0);
    wr_sr(32'h0000_009F);
    evt_i = 7'h40; @(negedge clk_i); evt_i = '0;
    chk("R8 fiq unmasked", sr_o, 32'h0000_00D1);

    // R9 return from interrupt mode
    do_reset();
    wr_sr(32'h6000_001F);
    evt_i = 7'h20; pc_i = 32'h2000; @(negedge clk_i); evt_i = '0;
    chk("R9 entered irq", sr_o, 32'h6000_0092);
    chk("R9 lr_ridx irq", {26'b0, lr_ridx_o}, 24);
    @(negedge clk_i);
    link_rdata_i = 32'h2004; ret_i = 1'b1; @(negedge clk_i); ret_i = 1'b0;
    chk("R9 restored sr", sr_o, 32'h6000_001F);
    chk("R9 pc from link", pc_val_o, 32'h2004);
    chk("R9 pc_load", {31'b0, pc_load_o}, 1);
    chk("R9 no link write", {31'b0, lr_we_o}, 0);
    ret_i = 1'b1; @(negedge clk_i); ret_i = 1'b0;
    chk("R9 ignored in sys", {31'b0, pc_load_o}, 0);
    chk("R9 sys sr kept", sr_o, 32'h6000_001F);

    // R11 event beats return, return beats status write
    evt_i = 7'h20; @(negedge clk_i); evt_i = '0;
    @(negedge clk_i);
    evt_i = 7'h01; ret_i = 1'b1; @(negedge clk_i); evt_i = '0; ret_i = 1'b0;
    chk("R11 event wins", sr_o, 32'h6000_00D3);
    chk("R11 link write", {31'b0, lr_we_o}, 1);
    ret_i = 1'b1; sr_we_i = 1'b1; sr_wdata_i = 32'h0000_001F;
    @(negedge clk_i); ret_i = 1'b0; sr_we_i = 1'b0;
    chk("R11 return wins", sr_o, 32'h6000_0092);

    // R10 status writes
    do_reset();
    wr_sr(32'h0000_0015);
    chk("R10 bad mode ignored", sr_o, 32'h0000_00D3);
    wr_sr(32'h0000_003F);
    chk("R10 state bit kept", sr_o, 32'h0000_001F);
    wr_sr(32'hF000_0010);
    chk("R10 user write", sr_o, 32'hF000_0010);

    finish_up();
  end
endmodule